// File: doc/BRIEF.md
# External Interrupt Sensitivity Controller

This block holds one 8-bit control register and turns four groups of external interrupt pins, plus one dedicated top-level interrupt pin, into interrupt requests. Every pin is first brought into the clock domain by a two-flop synchroniser. Each group then runs a small pending-flag state machine. The register chooses, for each pair of groups, whether a request comes from a falling edge plus a low level, a rising edge, a falling edge or either edge. Two of the groups can have their polarity flipped. The top-level pin has its own edge choice and an enable bit.

Firmware reaches the register through a single-cycle write strobe, and the register value is always present on the read bus. The sensitivity and polarity fields accept new values only while the CPU reports priority level 3. The top-level edge bit accepts new values only while that interrupt is disabled. An edge request stays up until software pulses the clear strobe for its group. A level request stays up for as long as any pin in the group sits at its active level.

Top module: `extirq_sense_ctrl`

Group numbering on `irq` and `clr`:

| Index | Pins | Mode field | Polarity bit |
|---|---|---|---|
| 0 | `pa_pins` | bits 4:3 | bit 2 |
| 1 | `pf_pins` | bits 4:3 | none |
| 2 | `pb_pins[3:0]` | bits 7:6 | bit 5 |
| 3 | `pb_pins[7:4]` | bits 7:6 | none |

Each group runs a pending machine with two states, PEND_IDLE and PEND_SET. The transition IDLE→SET happens on an active edge. The transition SET→IDLE happens on a clear strobe, unless an active edge arrives in the same cycle.

The top-level pin runs a machine with four states. The transitions are:
- TLI_OFF→TLI_ARMED when the enable bit is set.
- TLI_ARMED→TLI_HELD on the selected edge.
- TLI_HELD→TLI_ARMED on the clear strobe, unless an edge arrives in the same cycle.
- TLI_ARMED or TLI_HELD → TLI_GLITCH when the enable bit is cleared.
- TLI_GLITCH→TLI_OFF, or back to TLI_ARMED if the enable bit is set again.

## Requirements
- R1: After reset the register reads 00h, and with all pins held high no request output is active.
- R2: Bits 7:2 take the written value only when `cpu_lvl` is 2'b11. Otherwise they keep their value while bits 1:0 of the same write still update.
- R3: Bit 1 (top-level edge: 0 falling, 1 rising) takes the written value only when the stored bit 0 (top-level enable) is 0. Bit 0 is written on every write.
- R4: `rd_data` shows the register contents with no wait state, so a write is visible from the cycle after the strobe.
- R5: With the polarity bit clear, mode code 00 means falling edge plus low level, 01 means rising edge only, 10 means falling edge only, and 11 means both edges.
- R6: With the polarity bit set, groups 0 and 2 map code 00 to rising edge plus high level, 01 to falling only, 10 to rising only, and 11 to both edges.
- R7: Groups 1 and 3 always use the R5 mapping, whatever bits 2 and 5 hold.
- R8: In code 00 a group's request stays active while any pin of the group is at the active level, even when its clear strobe is pulsed.
- R9: An active edge sets a pending flag that holds the request until the group's clear strobe. When a clear and a new edge fall in the same cycle, the flag stays set.
- R10: A group's request is the OR over its pins and is independent of the other groups.
- R11: When enabled, the top-level pin sets a pending request on its selected edge, held until `tli_clr`. The opposite edge and the disabled state produce nothing.
- R12: Clearing the top-level enable produces exactly one cycle of `tli_irq`. After that, `tli_irq` stays low while the enable remains 0.
- R13: A pin change reaches a level request after two clock edges, through the synchroniser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle register write strobe |
| wr_data | input | 8 | Write data |
| cpu_lvl | input | 2 | Current CPU interrupt priority level (bit 1 = I1, bit 0 = I0) |
| rd_data | output | 8 | Register contents |
| pa_pins | input | PA_W (4) | Group 0 pins |
| pf_pins | input | PF_W (3) | Group 1 pins |
| pb_pins | input | PB_W (8) | Groups 2 (low half) and 3 (high half) pins |
| tli_pin | input | 1 | Top-level interrupt pin |
| clr | input | 4 | Per-group pending clear strobes |
| tli_clr | input | 1 | Top-level pending clear strobe |
| irq | output | 4 | Per-group interrupt requests |
| tli_irq | output | 1 | Top-level interrupt request |

## Verification
The hardest case to reach is a clear strobe that lands in the same cycle as a freshly detected edge. The bench sets a pending flag first, then changes a pin on a falling clock edge and counts two rising edges through the synchroniser. It raises the clear strobe for exactly the third edge, so clear and detection meet. The single-cycle glitch on disabling the top-level interrupt is checked by sampling on the first and second edges after the register write.

// File: rtl/extirq_pkg.sv
package extirq_pkg;

    // Mode codes as seen with the polarity bit clear
    typedef enum logic [1:0] {
        SENSE_LVL_EDGE = 2'b00,
        SENSE_RISE     = 2'b01,
        SENSE_FALL     = 2'b10,
        SENSE_ANY      = 2'b11
    } sense_e;

    typedef enum logic {
        PEND_IDLE,
        PEND_SET
    } pend_e;

    typedef enum logic [1:0] {
        TLI_OFF,
        TLI_ARMED,
        TLI_HELD,
        TLI_GLITCH
    } tli_e;

    localparam int CTL_W      = 8;
    localparam int BIT_TLI_EN = 0;
    localparam int BIT_TLI_RS = 1;
    localparam int BIT_INV_LO = 2;
    localparam int BIT_SEN_LO = 3;
    localparam int BIT_INV_HI = 5;
    localparam int BIT_SEN_HI = 6;
    localparam int PROT_LSB   = 2;

endpackage

// File: rtl/extirq_sync.sv
module extirq_sync #(
    parameter int             W       = 16,
    parameter logic [W-1:0]   RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/extirq_group.sv
module extirq_group
    import extirq_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins_s,
    input  sense_e       mode,
    input  logic         invert,
    input  logic         clr,
    output logic         req
);
    logic [W-1:0] prev;
    logic         rise_raw, fall_raw, act_rise, act_fall;
    logic         hit, lvl_on;
    pend_e        st, st_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= '1;
        else        prev <= pins_s;
    end

    // Polarity swaps the edge terms, so flipping it creates no false edge
    always_comb begin
        rise_raw = |(pins_s & ~prev);
        fall_raw = |(~pins_s & prev);
        act_rise = invert ? fall_raw : rise_raw;
        act_fall = invert ? rise_raw : fall_raw;
        hit      = 1'b0;
        lvl_on   = 1'b0;
        unique case (mode)
            SENSE_LVL_EDGE: begin
                hit    = act_fall;
                lvl_on = invert ? (|pins_s) : (|(~pins_s));
            end
            SENSE_RISE: hit = act_rise;
            SENSE_FALL: hit = act_fall;
            SENSE_ANY:  hit = act_rise | act_fall;
        endcase
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            PEND_IDLE: if (hit)         st_nx = PEND_SET;
            PEND_SET:  if (clr && !hit) st_nx = PEND_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= PEND_IDLE;
        else        st <= st_nx;
    end

    always_comb req = (st == PEND_SET) || lvl_on;
endmodule

// File: rtl/extirq_tli.sv
module extirq_tli
    import extirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_s,
    input  logic enable,
    input  logic rise_sel,
    input  logic clr,
    output logic req
);
    logic prev;
    logic edge_hit;
    tli_e st, st_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= 1'b1;
        else        prev <= pin_s;
    end

    always_comb edge_hit = rise_sel ? (pin_s & ~prev) : (~pin_s & prev);

    always_comb begin
        st_nx = st;
        unique case (st)
            TLI_OFF:    if (enable) st_nx = TLI_ARMED;
            TLI_ARMED: begin
                if (!enable)       st_nx = TLI_GLITCH;
                else if (edge_hit) st_nx = TLI_HELD;
            end
            TLI_HELD: begin
                if (!enable)              st_nx = TLI_GLITCH;
                else if (clr && !edge_hit) st_nx = TLI_ARMED;
            end
            TLI_GLITCH: st_nx = enable ? TLI_ARMED : TLI_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= TLI_OFF;
        else        st <= st_nx;
    end

    always_comb req = (st == TLI_HELD) || (st == TLI_GLITCH);
endmodule

// File: rtl/extirq_sense_ctrl.sv
module extirq_sense_ctrl
    import extirq_pkg::*;
#(
    parameter int PA_W = 4,
    parameter int PF_W = 3,
    parameter int PB_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    input  logic [1:0]        cpu_lvl,
    output logic [7:0]        rd_data,
    input  logic [PA_W-1:0]   pa_pins,
    input  logic [PF_W-1:0]   pf_pins,
    input  logic [PB_W-1:0]   pb_pins,
    input  logic              tli_pin,
    input  logic [3:0]        clr,
    input  logic              tli_clr,
    output logic [3:0]        irq,
    output logic              tli_irq
);
    localparam int PBH   = PB_W / 2;
    localparam int PIN_W = PA_W + PF_W + PB_W + 1;
    localparam int OFS_F = PA_W;
    localparam int OFS_B = PA_W + PF_W;

    logic [CTL_W-1:0] ctl, ctl_nx;
    logic [PIN_W-1:0] pins_s;
    logic [PA_W-1:0]  pa_s;
    logic [PF_W-1:0]  pf_s;
    logic [PB_W-1:0]  pb_s;
    logic             tli_s;

    // Register with per-field write protection
    always_comb begin
        ctl_nx = ctl;
        if (wr_en) begin
            if (cpu_lvl == 2'b11)
                ctl_nx[CTL_W-1:PROT_LSB] = wr_data[CTL_W-1:PROT_LSB];
            if (!ctl[BIT_TLI_EN])
                ctl_nx[BIT_TLI_RS] = wr_data[BIT_TLI_RS];
            ctl_nx[BIT_TLI_EN] = wr_data[BIT_TLI_EN];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl <= '0;
        else        ctl <= ctl_nx;
    end

    always_comb rd_data = ctl;

    extirq_sync #(.W(PIN_W), .RST_VAL({PIN_W{1'b1}})) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({tli_pin, pb_pins, pf_pins, pa_pins}),
        .q     (pins_s)
    );

    always_comb begin
        pa_s  = pins_s[PA_W-1:0];
        pf_s  = pins_s[OFS_F +: PF_W];
        pb_s  = pins_s[OFS_B +: PB_W];
        tli_s = pins_s[PIN_W-1];
    end

    extirq_group #(.W(PA_W)) u_grp_a (
        .clk(clk), .rst_n(rst_n), .pins_s(pa_s),
        .mode(sense_e'(ctl[BIT_SEN_LO +: 2])), .invert(ctl[BIT_INV_LO]),
        .clr(clr[0]), .req(irq[0])
    );

    extirq_group #(.W(PF_W)) u_grp_f (
        .clk(clk), .rst_n(rst_n), .pins_s(pf_s),
        .mode(sense_e'(ctl[BIT_SEN_LO +: 2])), .invert(1'b0),
        .clr(clr[1]), .req(irq[1])
    );

    extirq_group #(.W(PBH)) u_grp_bl (
        .clk(clk), .rst_n(rst_n), .pins_s(pb_s[PBH-1:0]),
        .mode(sense_e'(ctl[BIT_SEN_HI +: 2])), .invert(ctl[BIT_INV_HI]),
        .clr(clr[2]), .req(irq[2])
    );

    extirq_group #(.W(PB_W-PBH)) u_grp_bh (
        .clk(clk), .rst_n(rst_n), .pins_s(pb_s[PB_W-1:PBH]),
        .mode(sense_e'(ctl[BIT_SEN_HI +: 2])), .invert(1'b0),
        .clr(clr[3]), .req(irq[3])
    );

    extirq_tli u_tli (
        .clk(clk), .rst_n(rst_n), .pin_s(tli_s),
        .enable(ctl[BIT_TLI_EN]), .rise_sel(ctl[BIT_TLI_RS]),
        .clr(tli_clr), .req(tli_irq)
    );
endmodule

// File: rtl/extirq_sense_ctrl_chk.sv
module extirq_sense_ctrl_chk #(
    parameter int PF_W = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic [7:0]      wr_data,
    input logic [1:0]      cpu_lvl,
    input logic [7:0]      rd_data,
    input logic [3:0]      clr,
    input logic [3:0]      irq,
    input logic            tli_irq,
    input logic [PF_W-1:0] pf_s
);
    assert_prot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cpu_lvl != 2'b11) |=> (rd_data[7:2] == $past(rd_data[7:2])));

    assert_edge_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_data[0]) |=> (rd_data[1] == $past(rd_data[1])));

    assert_readback_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cpu_lvl == 2'b11 && !rd_data[0]) |=> (rd_data == $past(wr_data)));

    assert_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[4:3] == 2'b00 && !(&pf_s)) |-> irq[1]);

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq[3] && rd_data[7:6] != 2'b00 && !clr[3]) |=> irq[3]);

    assert_glitch_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_data[0]) |=> tli_irq);

    assert_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_data[0] && !$past(rd_data[0]) && !$past(rd_data[0], 2)) |-> !tli_irq);
endmodule

bind extirq_sense_ctrl extirq_sense_ctrl_chk #(.PF_W(PF_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .cpu_lvl (cpu_lvl),
    .rd_data (rd_data),
    .clr     (clr),
    .irq     (irq),
    .tli_irq (tli_irq),
    .pf_s    (pf_s)
);

// File: tb/tb_extirq_sense_ctrl.sv
module tb_extirq_sense_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] cpu_lvl = '0;
    logic [7:0] rd_data;
    logic [3:0] pa_pins = '1;
    logic [2:0] pf_pins = '1;
    logic [7:0] pb_pins = '1;
    logic       tli_pin = 1'b1;
    logic [3:0] clr = '0;
    logic       tli_clr = 1'b0;
    logic [3:0] irq;
    logic       tli_irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    extirq_sense_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .cpu_lvl(cpu_lvl), .rd_data(rd_data), .pa_pins(pa_pins),
        .pf_pins(pf_pins), .pb_pins(pb_pins), .tli_pin(tli_pin),
        .clr(clr), .tli_clr(tli_clr), .irq(irq), .tli_irq(tli_irq)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [1:0] lvl, input logic [7:0] d);
        @(negedge clk);
        cpu_lvl = lvl; wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(posedge clk);
        #1;
    endtask

    task automatic pulse_clr(input logic [3:0] m, input logic t);
        @(negedge clk);
        clr = m; tli_clr = t;
        @(negedge clk);
        clr = '0; tli_clr = 1'b0;
    endtask

    task automatic cleanup();
        @(negedge clk);
        pa_pins = '1; pf_pins = '1; pb_pins = '1;
        settle();
        pulse_clr(4'hF, 1'b1);
        settle();
    endtask

    task automatic t_reset();
        settle();
        chk("R1 reg", rd_data, 8'h00);
        chk("R1 irq", {4'h0, irq}, 8'h00);
        chk("R1 tli", {7'h0, tli_irq}, 8'h00);
    endtask

    task automatic t_protect();
        wr(2'b00, 8'hFF); chk("R2 low level write", rd_data, 8'h03);
        wr(2'b11, 8'h00); chk("R3 edge locked", rd_data, 8'h02);
        wr(2'b00, 8'h00); chk("R3 edge free", rd_data, 8'h00);
        wr(2'b11, 8'hF8); chk("R4 readback", rd_data, 8'hF8);
        wr(2'b10, 8'h04); chk("R2 level2 ignored", rd_data, 8'hF8);
        wr(2'b01, 8'h07); chk("R2 mixed write", rd_data, 8'hFB);
        wr(2'b11, 8'h00); chk("R3 locked again", rd_data, 8'h02);
        wr(2'b11, 8'h00); chk("R4 cleared", rd_data, 8'h00);
        cleanup();
    endtask

    task automatic t_level();
        @(negedge clk); pa_pins[0] = 1'b0;
        @(posedge clk); #1; chk("R13 one edge", {7'h0, irq[0]}, 8'h00);
        @(posedge clk); #1; chk("R13 two edges", {7'h0, irq[0]}, 8'h01);
        @(negedge clk); pf_pins[2] = 1'b0;
        settle(); chk("R8 level f", {7'h0, irq[1]}, 8'h01);
        pulse_clr(4'b0011, 1'b0);
        settle(); chk("R8 clear ignored", {6'h0, irq[1:0]}, 8'h03);
        @(negedge clk); pa_pins = '1; pf_pins = '1;
        settle(); chk("R8 released", {6'h0, irq[1:0]}, 8'h00);
        @(negedge clk); pb_pins[0] = 1'b0; pb_pins[3] = 1'b0;
        settle(); chk("R10 two pins", {7'h0, irq[2]}, 8'h01);
        @(negedge clk); pb_pins[0] = 1'b1;
        pulse_clr(4'b0100, 1'b0);
        settle(); chk("R10 one pin left", {7'h0, irq[2]}, 8'h01);
        chk("R10 other group", {7'h0, irq[3]}, 8'h00);
        @(negedge clk); pb_pins[3] = 1'b1;
        settle(); chk("R10 none left", {7'h0, irq[2]}, 8'h00);
        cleanup();
    endtask

    task automatic t_edges();
        wr(2'b11, 8'h08);
        @(negedge clk); pa_pins[1] = 1'b0;
        settle(); chk("R5 rise ignores fall", {7'h0, irq[0]}, 8'h00);
        @(negedge clk); pa_pins[1] = 1'b1;
        settle(); chk("R5 rise", {7'h0, irq[0]}, 8'h01);
        settle(); chk("R9 held", {7'h0, irq[0]}, 8'h01);
        pulse_clr(4'b0001, 1'b0);
        settle(); chk("R9 cleared", {7'h0, irq[0]}, 8'h00);
        wr(2'b11, 8'h10);
        @(negedge clk); pf_pins[0] = 1'b0;
        settle(); chk("R5 fall", {7'h0, irq[1]}, 8'h01);
        @(negedge clk); pf_pins[0] = 1'b1;
        pulse_clr(4'b0010, 1'b0);
        settle(); chk("R5 fall ignores rise", {7'h0, irq[1]}, 8'h00);
        wr(2'b11, 8'hC0);
        @(negedge clk); pb_pins[6] = 1'b0;
        settle(); chk("R5 both fall", {7'h0, irq[3]}, 8'h01);
        pulse_clr(4'b1000, 1'b0);
        settle(); chk("R5 no level in 11", {7'h0, irq[3]}, 8'h00);
        @(negedge clk); pb_pins[6] = 1'b1;
        settle(); chk("R5 both rise", {7'h0, irq[3]}, 8'h01);
        // clear strobe coincides with a fresh edge (R9)
        @(negedge clk); pb_pins[5] = 1'b0;
        @(posedge clk);
        @(posedge clk); #1; clr = 4'b1000;
        @(posedge clk); #1; clr = '0;
        settle(); chk("R9 edge beats clear", {7'h0, irq[3]}, 8'h01);
        pulse_clr(4'b1000, 1'b0);
        settle(); chk("R9 clear after race", {7'h0, irq[3]}, 8'h00);
        cleanup();
        wr(2'b11, 8'h00);
        cleanup();
    endtask

    task automatic t_invert();
        wr(2'b11, 8'h24);
        settle(); chk("R6 R7 high level", {4'h0, irq}, 8'h05);
        wr(2'b11, 8'h2C);
        pulse_clr(4'b0011, 1'b0);
        @(negedge clk); pa_pins[1] = 1'b0; pf_pins[0] = 1'b0;
        settle(); chk("R6 R7 falling", {6'h0, irq[1:0]}, 8'h01);
        @(negedge clk); pa_pins[1] = 1'b1; pf_pins[0] = 1'b1;
        settle(); chk("R7 rising", {6'h0, irq[1:0]}, 8'h03);
        chk("R7 group 3 level", {7'h0, irq[3]}, 8'h00);
        wr(2'b11, 8'h00);
        cleanup();
        chk("R6 cleanup", {4'h0, irq}, 8'h00);
    endtask

    task automatic t_tli();
        wr(2'b11, 8'h01);
        @(negedge clk); tli_pin = 1'b0;
        settle(); chk("R11 falling", {7'h0, tli_irq}, 8'h01);
        pulse_clr(4'h0, 1'b1);
        settle(); chk("R11 cleared", {7'h0, tli_irq}, 8'h00);
        @(negedge clk); tli_pin = 1'b1;
        settle(); chk("R11 rise ignored", {7'h0, tli_irq}, 8'h00);
        wr(2'b11, 8'h03); chk("R3 edge locked on", rd_data, 8'h01);
        wr(2'b11, 8'h00);
        @(posedge clk); #1; chk("R12 glitch", {7'h0, tli_irq}, 8'h01);
        @(posedge clk); #1; chk("R12 single", {7'h0, tli_irq}, 8'h00);
        wr(2'b11, 8'h02); chk("R3 edge set", rd_data, 8'h02);
        @(negedge clk); tli_pin = 1'b0;
        settle(); @(negedge clk); tli_pin = 1'b1;
        settle(); chk("R11 disabled", {7'h0, tli_irq}, 8'h00);
        wr(2'b11, 8'h03);
        @(negedge clk); tli_pin = 1'b0;
        settle(); chk("R11 rise ignores fall", {7'h0, tli_irq}, 8'h00);
        @(negedge clk); tli_pin = 1'b1;
        settle(); chk("R11 rising", {7'h0, tli_irq}, 8'h01);
        wr(2'b11, 8'h02);
        @(posedge clk); #1; chk("R12 held to glitch", {7'h0, tli_irq}, 8'h01);
        @(posedge clk); #1; chk("R12 off", {7'h0, tli_irq}, 8'h00);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_protect();
        t_level();
        t_edges();
        t_invert();
        t_tli();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule